// File: doc/BRIEF.md
# Packed Word Multiply, Add and Interleave Unit

This block is a SIMD datapath for 64-bit operand vectors, each split into four independent 16-bit lanes. Every cycle it can accept two operand vectors and an operation code. It then computes one of several lane-wise results: the lower or upper half of each lane product, a lane sum (wrapping, signed-clamped or unsigned-clamped), or a word interleave that takes the lower or upper lane pair from each operand.

The split product halves and the interleave are meant to be used together. Issue the low-half product, then the high-half product, then interleave the two results. Each 32-bit slot of the interleaved output then holds a full 32-bit signed product. The result goes into a register, and a one-cycle valid strobe marks when a new result is present.

Top module: `pw_simd_unit`

## Requirements
- R1: Lanes are independent. A carry or overflow in one 16-bit lane never changes any other lane of the result.
- R2: Operation code 0 (multiply-low) returns bits 15:0 of each lane product. Lanes 0x01AC×0x0006, 0x2112×0x0137, 0x03F3×0x0AB7 and 0x00A4×0x00D8 give 0x0A08, 0x2CDE, 0x50B5 and 0x8A60.
- R3: Operation code 1 (multiply-high) returns bits 31:16 of each signed 16×16 lane product. For example, 0xFFFF×0x0002 gives 0xFFFF and 0x8000×0x8000 gives 0x4000. A lane with a zero operand gives 0x0000.
- R4: Operation code 2 adds each lane modulo 2^16.
- R5: Operation code 3 adds each lane as two's-complement values and clamps the sum to the range 0x8000 to 0x7FFF.
- R6: Operation code 4 adds each lane as unsigned values and clamps the sum to at most 0xFFFF.
- R7: Operation code 5 interleaves the lower lanes. From most to least significant, the result lanes are {b[1], a[1], b[0], a[0]}, where lane n occupies bits 16n+15:16n.
- R8: Operation code 6 interleaves the upper lanes. From most to least significant, the result lanes are {b[3], a[3], b[2], a[2]}.
- R9: Operation code 7 is unassigned and yields an all-zero result.
- R10: When in_valid is high at a rising clock edge, the result for that edge's operands appears after that edge, and out_valid is high for exactly that one cycle.
- R11: When in_valid is low at an edge, out_valid is low after that edge and result keeps its previous value.
- R12: While rst is high, out_valid and result are cleared to zero, whatever in_valid is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and op_sel are valid this cycle |
| op_sel | input | 3 | Operation code (see R2 to R9) |
| opnd_a | input | 64 | First operand, four 16-bit lanes |
| opnd_b | input | 64 | Second operand, four 16-bit lanes |
| out_valid | output | 1 | Result register was loaded at the last edge |
| result | output | 64 | Registered lane result |

## Verification
The hardest situations to reach are the clamp boundaries, where a lane sum lands exactly one past the limit. Both operands have to sit at the extreme codes 0x7FFF, 0x8000 or 0xFFFF in the same lane. Uniform random operands almost never produce that. The stimulus therefore draws each lane separately from a pool that is mostly extreme codes. It also mixes a saturating lane next to a non-saturating lane, so that a leak between lanes would show up. Directed table vectors pin the exact boundary sums and the known multiply and interleave chain.

// File: rtl/pw_simd_pkg.sv
package pw_simd_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_MUL_LO   = 3'd0,
    OP_MUL_HI   = 3'd1,
    OP_ADD_WRAP = 3'd2,
    OP_ADD_SSAT = 3'd3,
    OP_ADD_USAT = 3'd4,
    OP_MIX_LO   = 3'd5,
    OP_MIX_HI   = 3'd6,
    OP_NONE     = 3'd7
  } op_e;

endpackage

// File: rtl/pw_lane_mul.sv
module pw_lane_mul #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4
) (
  input  logic [LANE_W*LANES-1:0] a_vec,
  input  logic [LANE_W*LANES-1:0] b_vec,
  output logic [LANE_W*LANES-1:0] lo_vec,
  output logic [LANE_W*LANES-1:0] hi_vec
);

  localparam int PROD_W = 2 * LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] a_l, b_l;
    logic [PROD_W-1:0] a_x, b_x, prod;

    assign a_l  = a_vec[g*LANE_W +: LANE_W];
    assign b_l  = b_vec[g*LANE_W +: LANE_W];
    // sign-extend both lanes; low PROD_W bits of the product are the signed product
    assign a_x  = {{LANE_W{a_l[LANE_W-1]}}, a_l};
    assign b_x  = {{LANE_W{b_l[LANE_W-1]}}, b_l};
    assign prod = a_x * b_x;

    assign lo_vec[g*LANE_W +: LANE_W] = prod[LANE_W-1:0];
    assign hi_vec[g*LANE_W +: LANE_W] = prod[PROD_W-1:LANE_W];

    // R3: a zero factor must give a zero upper half
    always_comb begin
      p_hi_zero_r3: assert (!(a_l == '0 || b_l == '0) ||
                            hi_vec[g*LANE_W +: LANE_W] == '0);
    end
  end

endmodule

// File: rtl/pw_lane_add.sv
module pw_lane_add #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4
) (
  input  logic [LANE_W*LANES-1:0] a_vec,
  input  logic [LANE_W*LANES-1:0] b_vec,
  output logic [LANE_W*LANES-1:0] wrap_vec,
  output logic [LANE_W*LANES-1:0] ssat_vec,
  output logic [LANE_W*LANES-1:0] usat_vec
);

  localparam logic [LANE_W-1:0] S_MAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] S_MIN = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [LANE_W-1:0] U_MAX = {LANE_W{1'b1}};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] a_l, b_l, ssat_l, usat_l;
    logic [LANE_W:0]   sum_u, sum_s;

    assign a_l   = a_vec[g*LANE_W +: LANE_W];
    assign b_l   = b_vec[g*LANE_W +: LANE_W];
    assign sum_u = {1'b0, a_l} + {1'b0, b_l};
    assign sum_s = {a_l[LANE_W-1], a_l} + {b_l[LANE_W-1], b_l};

    // signed overflow: the extra sign bit disagrees with the lane sign bit
    assign ssat_l = (sum_s[LANE_W] != sum_s[LANE_W-1]) ?
                    (sum_s[LANE_W] ? S_MIN : S_MAX) : sum_s[LANE_W-1:0];
    assign usat_l = sum_u[LANE_W] ? U_MAX : sum_u[LANE_W-1:0];

    assign wrap_vec[g*LANE_W +: LANE_W] = sum_u[LANE_W-1:0];
    assign ssat_vec[g*LANE_W +: LANE_W] = ssat_l;
    assign usat_vec[g*LANE_W +: LANE_W] = usat_l;

    always_comb begin
      // R5: same-sign operands never produce a result of the opposite sign
      p_ssat_sign_r5: assert (a_l[LANE_W-1] != b_l[LANE_W-1] ||
                              ssat_l[LANE_W-1] == a_l[LANE_W-1]);
      // R6: an unsigned clamped sum never drops below either addend
      p_usat_floor_r6: assert (usat_l >= a_l && usat_l >= b_l);
    end
  end

endmodule

// File: rtl/pw_word_mix.sv
module pw_word_mix #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4
) (
  input  logic [LANE_W*LANES-1:0] a_vec,
  input  logic [LANE_W*LANES-1:0] b_vec,
  output logic [LANE_W*LANES-1:0] lo_vec,
  output logic [LANE_W*LANES-1:0] hi_vec
);

  localparam int HALF = LANES / 2;

  for (genvar i = 0; i < HALF; i++) begin : g_pair
    // even output lane from a, odd from b
    assign lo_vec[(2*i)*LANE_W   +: LANE_W] = a_vec[i*LANE_W        +: LANE_W];
    assign lo_vec[(2*i+1)*LANE_W +: LANE_W] = b_vec[i*LANE_W        +: LANE_W];
    assign hi_vec[(2*i)*LANE_W   +: LANE_W] = a_vec[(HALF+i)*LANE_W +: LANE_W];
    assign hi_vec[(2*i+1)*LANE_W +: LANE_W] = b_vec[(HALF+i)*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/pw_simd_unit.sv
module pw_simd_unit
  import pw_simd_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [OP_W-1:0]         op_sel,
  input  logic [LANE_W*LANES-1:0] opnd_a,
  input  logic [LANE_W*LANES-1:0] opnd_b,
  output logic                    out_valid,
  output logic [LANE_W*LANES-1:0] result
);

  localparam int VEC_W = LANE_W * LANES;

  logic [VEC_W-1:0] mul_lo, mul_hi, add_wrap, add_ssat, add_usat, mix_lo, mix_hi;
  logic [VEC_W-1:0] next_res;

  pw_lane_mul #(.LANE_W(LANE_W), .LANES(LANES)) u_mul (
    .a_vec (opnd_a), .b_vec (opnd_b), .lo_vec (mul_lo), .hi_vec (mul_hi)
  );

  pw_lane_add #(.LANE_W(LANE_W), .LANES(LANES)) u_add (
    .a_vec (opnd_a), .b_vec (opnd_b),
    .wrap_vec (add_wrap), .ssat_vec (add_ssat), .usat_vec (add_usat)
  );

  pw_word_mix #(.LANE_W(LANE_W), .LANES(LANES)) u_mix (
    .a_vec (opnd_a), .b_vec (opnd_b), .lo_vec (mix_lo), .hi_vec (mix_hi)
  );

  always_comb begin
    unique case (op_e'(op_sel))
      OP_MUL_LO:   next_res = mul_lo;
      OP_MUL_HI:   next_res = mul_hi;
      OP_ADD_WRAP: next_res = add_wrap;
      OP_ADD_SSAT: next_res = add_ssat;
      OP_ADD_USAT: next_res = add_usat;
      OP_MIX_LO:   next_res = mix_lo;
      OP_MIX_HI:   next_res = mix_hi;
      default:     next_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

  // R10: an accepted input raises the strobe on the next cycle
  p_valid_next_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R11: no input, no strobe, and the result register keeps its value
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));

  // R12: reset leaves the outputs cleared
  p_reset_clear_r12: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

endmodule

// File: tb/pw_simd_unit_tb.sv
module pw_simd_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  localparam int VW   = 3 + 64 * 3;

  // {op, a, b, expected}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {3'd0, 64'h00A4_03F3_2112_01AC, 64'h00D8_0AB7_0137_0006, 64'h8A60_50B5_2CDE_0A08}, // R2
    {3'd1, 64'h00A4_03F3_2112_01AC, 64'h00D8_0AB7_0137_0006, 64'h0000_002A_0028_0000}, // R3
    {3'd1, 64'h8000_FFFF_0002_7FFF, 64'h8000_0002_FFFF_7FFF, 64'h4000_FFFF_FFFF_3FFF}, // R3 signs
    {3'd2, 64'h0001_7FFF_FFFF_0000, 64'h0002_0001_0001_0000, 64'h0003_8000_0000_0000}, // R4, R1
    {3'd3, 64'h7FFF_8000_1234_FFFF, 64'h0001_FFFF_1111_0001, 64'h7FFF_8000_2345_0000}, // R5, R1
    {3'd4, 64'h7FFF_8000_1234_FFFF, 64'h0001_FFFF_1111_0001, 64'h8000_FFFF_2345_FFFF}, // R6, R1
    {3'd3, 64'h8000_8000_7FFF_7FFF, 64'h8000_FFFF_7FFF_0000, 64'h8000_8000_7FFF_7FFF}, // R5 edges
    {3'd4, 64'h8000_FFFF_0000_FFFF, 64'h8000_0000_0000_FFFF, 64'hFFFF_FFFF_0000_FFFF}, // R6 edges
    {3'd5, 64'h8A60_50B5_2CDE_0A08, 64'h0000_002A_0028_0000, 64'h0028_2CDE_0000_0A08}, // R7
    {3'd6, 64'h8A60_50B5_2CDE_0A08, 64'h0000_002A_0028_0000, 64'h0000_8A60_002A_50B5}, // R8
    {3'd7, 64'hFFFF_1234_5678_9ABC, 64'h1111_2222_3333_4444, 64'h0000_0000_0000_0000}  // R9
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic        out_valid;
  logic [63:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  pw_simd_unit dut_i (
    .clk (clk), .rst (rst), .in_valid (in_valid), .op_sel (op_sel),
    .opnd_a (opnd_a), .opnd_b (opnd_b), .out_valid (out_valid), .result (result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // lane-at-a-time reference
  function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [63:0] r = '0;
    for (int n = 0; n < 4; n++) begin
      int sa, sb, ua, ub, s;
      logic [15:0] lane;
      ua = int'(a[16*n +: 16]);
      ub = int'(b[16*n +: 16]);
      sa = (ua >= 32768) ? ua - 65536 : ua;
      sb = (ub >= 32768) ? ub - 65536 : ub;
      case (op)
        3'd0: begin s = sa * sb; lane = s[15:0]; end
        3'd1: begin s = sa * sb; lane = s[31:16]; end
        3'd2: begin s = ua + ub; lane = s[15:0]; end
        3'd3: begin s = sa + sb; if (s > 32767) s = 32767; if (s < -32768) s = -32768;
                    lane = s[15:0]; end
        3'd4: begin s = ua + ub; if (s > 65535) s = 65535; lane = s[15:0]; end
        3'd5: lane = (n % 2 == 0) ? a[16*(n/2) +: 16] : b[16*(n/2) +: 16];
        3'd6: lane = (n % 2 == 0) ? a[16*(2 + n/2) +: 16] : b[16*(2 + n/2) +: 16];
        default: lane = '0;
      endcase
      r[16*n +: 16] = lane;
    end
    return r;
  endfunction

  function automatic logic [15:0] corner_lane();
    case ($urandom_range(0, 7))
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      5: return 16'h8001;
      default: return 16'($urandom);
    endcase
  endfunction

  // one operation: drive at negedge, check after the accepting edge, then idle a cycle
  task automatic issue(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] exp, input string req);
    logic [63:0] held;
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 strobe", {63'd0, out_valid}, 64'd1);
    chk(req, result, exp);
    held = result;
    opnd_a = ~a; opnd_b = ~b; op_sel = op + 3'd1;
    @(negedge clk);
    chk("R11 strobe low", {63'd0, out_valid}, 64'd0);
    chk("R11 hold", result, held);
  endtask

  initial begin
    // R12: reset with in_valid high keeps outputs clear
    in_valid = 1'b1; opnd_a = 64'hFFFF_FFFF_FFFF_FFFF; opnd_b = 64'h1; op_sel = 3'd2;
    repeat (3) @(negedge clk);
    chk("R12 valid in reset", {63'd0, out_valid}, 64'd0);
    chk("R12 result in reset", result, 64'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R12 after reset", {63'd0, out_valid}, 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      issue(v[194:192], v[191:128], v[127:64], v[63:0], $sformatf("table[%0d] R1-set", i));
    end

    // random and corner-lane operands against the lane model (R1 R2 R3 R4 R5 R6 R7 R8 R9)
    for (int k = 0; k < 1600; k++) begin
      logic [63:0] a, b;
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      for (int n = 0; n < 4; n++) begin
        a[16*n +: 16] = (k % 2 == 0) ? corner_lane() : 16'($urandom);
        b[16*n +: 16] = (k % 2 == 0) ? corner_lane() : 16'($urandom);
      end
      issue(op, a, b, model(op, a, b), $sformatf("random op%0d R1 model", op));
    end

    // R10: back-to-back inputs produce back-to-back strobes and results
    @(negedge clk);
    in_valid = 1'b1; op_sel = 3'd2; opnd_a = 64'h1; opnd_b = 64'h2;
    @(negedge clk);
    chk("R10 b2b first", result, 64'h3);
    op_sel = 3'd5; opnd_a = 64'h4444_3333_2222_1111; opnd_b = 64'h8888_7777_6666_5555;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 b2b strobe", {63'd0, out_valid}, 64'd1);
    chk("R7 b2b second", result, 64'h6666_2222_5555_1111);
    @(negedge clk);
    chk("R11 after b2b", {63'd0, out_valid}, 64'd0);

    // R12: reset mid-stream clears a loaded result
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R12 mid-stream clear", result, 64'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule